// File: doc/BRIEF.md
# Receiver Configuration Two-Wire Slave

This block is the configuration port of a serial receiver. A host reaches it over a two-wire bus (clock and open-drain data) and uses a sub-addressed map of byte registers to set the receiver up and to read its status. The block answers to one 7-bit device address. That address is fixed apart from one bit, which a board-level strap input supplies, so two receivers can share a bus.

A write transaction sends the device address with the write flag, then a sub-address byte, then any number of data bytes. The sub-address steps up by one after each data byte. To read, the host writes only the sub-address, issues a repeated start with the read flag, and collects bytes. It acknowledges each byte it wants followed by another, and refuses the last one before the stop.

Command bits act on a write of 1 followed by a later write of 0. At that 1-to-0 change the block emits a pulse one system clock wide. The two control registers can only be written at their own sub-addresses. Their contents are read back at separate sub-addresses. A status register reports loss of signal and loss of lock. Loss of lock can be switched into a latched mode that holds the indication until the host clears it.

Top module: `rx_cfg_i2c_slave`

## Requirements
- R1: The block acknowledges only the 7-bit device address whose bit 6 is 1, bit 5 equals `addrPin` and bits 4..0 are 0. The eighth bit is the read/write flag (0 = write, 1 = read). Any other address gets no acknowledge and the block stays off the bus until the next start.
- R2: A write of device address, sub-address and data byte stores the data. Sub-address 0x08 holds the 3-bit command register. Sub-address 0x09 holds the 5-bit output register. Every byte of an addressed transaction is acknowledged.
- R3: Successive data bytes in one write go to successive sub-addresses.
- R4: A read through a repeated start returns the byte at the written sub-address MSB first. After each byte the host acknowledges, the next sub-address is returned. A refused byte ends the read.
- R5: The command register reads back at 0x05 and the output register at 0x06, zero-extended. Reading the write sub-addresses 0x08 or 0x09, or any unmapped sub-address, returns 0x00. Bits written above a register's width are dropped.
- R6: Command bit 2 (start acquisition) and output bit 4 (pattern kick) produce exactly one one-clock pulse on `acqPulse` / `prbsKickPulse` when the stored bit changes from 1 to 0. Writing 1, or rewriting 0, produces none.
- R7: With command bit 0 set (latched mode), `lolOut` goes high once `lolRaw` is high and stays high after `lolRaw` falls. It clears only on a 1-then-0 write of command bit 1.
- R8: With command bit 0 clear, `lolOut` follows `lolRaw`.
- R9: Output bit 0 selects loss-of-signal polarity. When it is 0, `losOut` equals `losRaw`. When it is 1, `losOut` is the inverse of `losRaw`.
- R10: Output bits 3..1 form the pattern mode. 001 asserts `prbsGen`, 100 asserts `prbsDet`, and 000 and all other codes assert neither.
- R11: Writes to unmapped sub-addresses are acknowledged and have no effect on any register.
- R12: After reset all registers are 0, `sdaOe` is low and no pulse is active. Status at sub-address 0x04 returns `losRaw` in bit 0 and the `lolOut` value in bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addrPin | input | 1 | Strap for device address bit 5 |
| sclIn | input | 1 | Bus clock, already synchronized |
| sdaIn | input | 1 | Bus data line level, already synchronized |
| sdaOe | output | 1 | 1 pulls the data line low |
| losRaw | input | 1 | Loss-of-signal indication from the receiver |
| lolRaw | input | 1 | Loss-of-lock indication from the receiver |
| losOut | output | 1 | Loss-of-signal output with selected polarity |
| lolOut | output | 1 | Loss-of-lock output, direct or latched |
| acqPulse | output | 1 | One-clock start-acquisition pulse |
| prbsKickPulse | output | 1 | One-clock pattern-sequence start pulse |
| prbsGen | output | 1 | Pattern generator mode selected |
| prbsDet | output | 1 | Pattern checker mode selected |

## Verification
The bench targets the address strap: it acknowledges the pin-dependent address and refuses the same byte once the strap flips. A design that hard-wired bit 5 would answer the wrong device. It probes the 1-then-0 command rule by counting pulses over set, clear and repeated-clear writes. A design triggering on a rising edge or on every write would show a count off by one. It clears latched loss of lock while the raw indication is low. It reads write-only sub-addresses and unmapped sub-addresses, so a map that aliased them would return stored data instead of zero. Multi-byte writes and reads with acknowledged continuation catch a sub-address pointer that fails to step, or that steps twice.

// File: rtl/rxcfg_pkg.sv
package rxcfg_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic              ptrLoad;
    logic              wrEn;
    logic              rdNext;
    logic [BYTE_W-1:0] byteVal;
  } linkStrobe_t;

  typedef enum logic [3:0] {
    LS_IDLE, LS_ADDR, LS_ADDR_ACK, LS_SUB, LS_SUB_ACK,
    LS_WDATA, LS_WDATA_ACK, LS_RDATA, LS_RDATA_ACK
  } linkState_t;
endpackage

// File: rtl/i2c_link_ctrl.sv
module i2c_link_ctrl
  import rxcfg_pkg::*;
#(
  parameter int                PIN_POS    = 5,
  parameter logic [BYTE_W-2:0] ADDR_FIXED = 7'h40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrPin,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [BYTE_W-1:0] rdData,
  output logic              sdaOe,
  output linkStrobe_t       strb
);
  localparam int ADDR_W = BYTE_W - 1;
  localparam int CNT_W  = $clog2(BYTE_W);

  linkState_t        state;
  logic              sclQ, sdaQ;
  logic [CNT_W-1:0]  cnt;
  logic              byteFull, rwQ, mAckQ;
  logic [BYTE_W-1:0] shiftQ, txQ;
  logic [ADDR_W-1:0] devAddr;
  logic              sclRise, sclFall, startSeen, stopSeen, rxPhase, addrHit;

  always_comb begin
    devAddr          = ADDR_FIXED;
    devAddr[PIN_POS] = addrPin;
  end

  assign sclRise   = sclIn & ~sclQ;
  assign sclFall   = ~sclIn & sclQ;
  assign startSeen = sclIn & sclQ & sdaQ & ~sdaIn;
  assign stopSeen  = sclIn & sclQ & ~sdaQ & sdaIn;
  assign rxPhase   = (state == LS_ADDR) || (state == LS_SUB) || (state == LS_WDATA);
  assign addrHit   = (shiftQ[BYTE_W-1:1] == devAddr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ     <= 1'b1;
      sdaQ     <= 1'b1;
      state    <= LS_IDLE;
      cnt      <= '0;
      byteFull <= 1'b0;
      rwQ      <= 1'b0;
      mAckQ    <= 1'b0;
      shiftQ   <= '0;
      txQ      <= '0;
    end else begin
      sclQ <= sclIn;
      sdaQ <= sdaIn;
      if (startSeen) begin
        state    <= LS_ADDR;
        cnt      <= '0;
        byteFull <= 1'b0;
      end else if (stopSeen) begin
        state    <= LS_IDLE;
        byteFull <= 1'b0;
      end else begin
        if (sclRise) begin
          if (rxPhase) shiftQ <= {shiftQ[BYTE_W-2:0], sdaIn};
          if (rxPhase || state == LS_RDATA) begin
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(BYTE_W - 1)) byteFull <= 1'b1;
          end
          if (state == LS_RDATA_ACK) mAckQ <= ~sdaIn;
        end
        if (sclFall) begin
          case (state)
            LS_ADDR: if (byteFull) begin
              byteFull <= 1'b0;
              rwQ      <= shiftQ[0];
              state    <= addrHit ? LS_ADDR_ACK : LS_IDLE;
            end
            LS_SUB: if (byteFull) begin
              byteFull <= 1'b0;
              state    <= LS_SUB_ACK;
            end
            LS_WDATA: if (byteFull) begin
              byteFull <= 1'b0;
              state    <= LS_WDATA_ACK;
            end
            LS_ADDR_ACK: begin
              if (rwQ) begin
                txQ   <= rdData;
                state <= LS_RDATA;
              end else begin
                state <= LS_SUB;
              end
            end
            LS_SUB_ACK, LS_WDATA_ACK: state <= LS_WDATA;
            LS_RDATA: begin
              if (byteFull) begin
                byteFull <= 1'b0;
                state    <= LS_RDATA_ACK;
              end else begin
                txQ <= {txQ[BYTE_W-2:0], 1'b0};
              end
            end
            LS_RDATA_ACK: begin
              if (mAckQ) begin
                txQ   <= rdData;
                state <= LS_RDATA;
              end else begin
                state <= LS_IDLE;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    strb         = '0;
    strb.byteVal = shiftQ;
    if (sclFall && !startSeen && !stopSeen) begin
      strb.ptrLoad = (state == LS_SUB) && byteFull;
      strb.wrEn    = (state == LS_WDATA) && byteFull;
      strb.rdNext  = ((state == LS_ADDR_ACK) && rwQ) || ((state == LS_RDATA_ACK) && mAckQ);
    end
  end

  always_comb begin
    case (state)
      LS_ADDR_ACK, LS_SUB_ACK, LS_WDATA_ACK: sdaOe = 1'b1;
      LS_RDATA:                              sdaOe = ~txQ[BYTE_W-1];
      default:                               sdaOe = 1'b0;
    endcase
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strb.ptrLoad, strb.wrEn, strb.rdNext}) <= 1); // R2

  AST_MISS_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (state == LS_ADDR && sclFall && byteFull && !addrHit && !startSeen && !stopSeen)
      |=> (!sdaOe && state == LS_IDLE)); // R1
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import rxcfg_pkg::*;
#(
  parameter logic [BYTE_W-1:0] SUB_STATUS = 8'h04,
  parameter logic [BYTE_W-1:0] SUB_RB_CMD = 8'h05,
  parameter logic [BYTE_W-1:0] SUB_RB_OUT = 8'h06,
  parameter logic [BYTE_W-1:0] SUB_WR_CMD = 8'h08,
  parameter logic [BYTE_W-1:0] SUB_WR_OUT = 8'h09,
  parameter int                CMD_W      = 3,
  parameter int                OUT_W      = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  linkStrobe_t       strb,
  input  logic              losRaw,
  input  logic              lolRaw,
  output logic [BYTE_W-1:0] rdData,
  output logic              losOut,
  output logic              lolOut,
  output logic              acqPulse,
  output logic              prbsKickPulse,
  output logic              prbsGen,
  output logic              prbsDet
);
  localparam int NUM_KICK = 3;
  localparam int KICK_CLR = 0;
  localparam int KICK_ACQ = 1;
  localparam int KICK_PAT = 2;

  logic [BYTE_W-1:0] ptrQ;
  logic [CMD_W-1:0]  cmdQ;
  logic [OUT_W-1:0]  outQ;
  logic              stickyQ;
  logic [NUM_KICK-1:0] kickBits, kickDlyQ, kickPulse;
  logic [2:0]        patMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ <= '0;
      cmdQ <= '0;
      outQ <= '0;
    end else begin
      if (strb.ptrLoad)                 ptrQ <= strb.byteVal;
      else if (strb.wrEn || strb.rdNext) ptrQ <= ptrQ + 1'b1;
      if (strb.wrEn) begin
        if (ptrQ == SUB_WR_CMD) cmdQ <= strb.byteVal[CMD_W-1:0];
        if (ptrQ == SUB_WR_OUT) outQ <= strb.byteVal[OUT_W-1:0];
      end
    end
  end

  assign kickBits = {outQ[4], cmdQ[2], cmdQ[1]};

  for (genvar g = 0; g < NUM_KICK; g++) begin : g_kick
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) kickDlyQ[g] <= 1'b0;
      else       kickDlyQ[g] <= kickBits[g];
    end
    assign kickPulse[g] = kickDlyQ[g] & ~kickBits[g];

    AST_KICK_ONE_WIDE: assert property (@(posedge clk) disable iff (!rstN)
      kickPulse[g] |=> !kickPulse[g]); // R6
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    stickyQ <= 1'b0;
    else if (kickPulse[KICK_CLR]) stickyQ <= 1'b0;
    else if (cmdQ[0] && lolRaw)   stickyQ <= 1'b1;
  end

  assign lolOut        = cmdQ[0] ? stickyQ : lolRaw;
  assign losOut        = losRaw ^ outQ[0];
  assign acqPulse      = kickPulse[KICK_ACQ];
  assign prbsKickPulse = kickPulse[KICK_PAT];
  assign patMode       = outQ[3:1];
  assign prbsGen       = (patMode == 3'b001);
  assign prbsDet       = (patMode == 3'b100);

  always_comb begin
    rdData = '0;
    if (ptrQ == SUB_STATUS) begin
      rdData[0] = losRaw;
      rdData[1] = lolOut;
    end else if (ptrQ == SUB_RB_CMD) begin
      rdData[CMD_W-1:0] = cmdQ;
    end else if (ptrQ == SUB_RB_OUT) begin
      rdData[OUT_W-1:0] = outQ;
    end
  end

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && !strb.ptrLoad) |=> (ptrQ == $past(ptrQ) + 8'd1)); // R3

  AST_UNMAPPED_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && ptrQ != SUB_WR_CMD && ptrQ != SUB_WR_OUT)
      |=> ($stable(cmdQ) && $stable(outQ))); // R11

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cmdQ[0] && lolOut && !kickPulse[KICK_CLR] && !strb.wrEn) |=> lolOut); // R7
endmodule

// File: rtl/rx_cfg_i2c_slave.sv
module rx_cfg_i2c_slave
  import rxcfg_pkg::*;
#(
  parameter int                PIN_POS    = 5,
  parameter logic [BYTE_W-2:0] ADDR_FIXED = 7'h40
) (
  input  logic clk,
  input  logic rstN,
  input  logic addrPin,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOe,
  input  logic losRaw,
  input  logic lolRaw,
  output logic losOut,
  output logic lolOut,
  output logic acqPulse,
  output logic prbsKickPulse,
  output logic prbsGen,
  output logic prbsDet
);
  linkStrobe_t       strb;
  logic [BYTE_W-1:0] rdData;

  i2c_link_ctrl #(.PIN_POS(PIN_POS), .ADDR_FIXED(ADDR_FIXED)) i_ctrl (
    .clk(clk), .rstN(rstN), .addrPin(addrPin), .sclIn(sclIn), .sdaIn(sdaIn),
    .rdData(rdData), .sdaOe(sdaOe), .strb(strb)
  );

  cfg_regfile i_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .losRaw(losRaw), .lolRaw(lolRaw),
    .rdData(rdData), .losOut(losOut), .lolOut(lolOut), .acqPulse(acqPulse),
    .prbsKickPulse(prbsKickPulse), .prbsGen(prbsGen), .prbsDet(prbsDet)
  );
endmodule

// File: tb/test_rx_cfg_i2c_slave.sv
module test_rx_cfg_i2c_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 4;
  localparam int WDOG       = 150000;
  localparam int NVEC       = 8;
  // {write sub, write data, read sub, expected read}
  localparam logic [31:0] VECS [0:NVEC-1] = '{
    32'h09_03_06_03, 32'h09_08_06_08, 32'h09_EE_06_0E, 32'h08_01_05_01,
    32'h08_00_05_00, 32'h08_F8_05_00, 32'h09_0A_08_00, 32'h10_5A_10_00
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic addrPin = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic losRaw = 1'b0, lolRaw = 1'b0;
  logic sdaOe, losOut, lolOut, acqPulse, prbsKickPulse, prbsGen, prbsDet;
  logic sdaLine;
  int checks = 0, fails = 0;
  int acqCnt = 0, patCnt = 0, wideCnt = 0;
  logic acqPrev = 1'b0, patPrev = 1'b0;
  bit done = 0;

  assign sdaLine = sdaM & ~sdaOe;
  always #(CLK_PERIOD/2) clk = ~clk;

  rx_cfg_i2c_slave i_rx_cfg_i2c_slave (
    .clk(clk), .rstN(rstN), .addrPin(addrPin), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaOe(sdaOe), .losRaw(losRaw), .lolRaw(lolRaw), .losOut(losOut),
    .lolOut(lolOut), .acqPulse(acqPulse), .prbsKickPulse(prbsKickPulse),
    .prbsGen(prbsGen), .prbsDet(prbsDet)
  );

  always @(posedge clk) begin
    if (acqPulse) acqCnt <= acqCnt + 1;
    if (prbsKickPulse) patCnt <= patCnt + 1;
    if ((acqPulse && acqPrev) || (prbsKickPulse && patPrev)) wideCnt <= wideCnt + 1;
    acqPrev <= acqPulse;
    patPrev <= prbsKickPulse;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic qWait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; qWait(); sclM = 1'b1; qWait(); sdaM = 1'b0; qWait(); sclM = 1'b0; qWait();
  endtask

  task automatic busStop();
    sdaM = 1'b0; qWait(); sclM = 1'b1; qWait(); sdaM = 1'b1; qWait();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; qWait(); sclM = 1'b1; qWait(); qWait(); sclM = 1'b0; qWait();
    end
    sdaM = 1'b1; qWait(); sclM = 1'b1; qWait(); ack = ~sdaLine; qWait(); sclM = 1'b0; qWait();
  endtask

  task automatic recvByte(input logic ack, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qWait(); sclM = 1'b1; qWait(); b[i] = sdaLine; qWait(); sclM = 1'b0;
    end
    qWait(); sdaM = ~ack; qWait(); sclM = 1'b1; qWait(); qWait(); sclM = 1'b0; qWait();
    sdaM = 1'b1;
  endtask

  function automatic logic [7:0] devByte(input logic rd);
    return {1'b1, addrPin, 5'b00000, rd};
  endfunction

  task automatic regWrite(input logic [7:0] sub, input logic [7:0] d);
    logic a0, a1, a2;
    busStart(); sendByte(devByte(1'b0), a0); sendByte(sub, a1); sendByte(d, a2); busStop();
    check(a0 & a1 & a2, "R2 write acknowledged", {29'd0, a0, a1, a2}, 32'h7);
  endtask

  task automatic regWrite2(input logic [7:0] sub, input logic [7:0] d0, input logic [7:0] d1);
    logic a0, a1, a2, a3;
    busStart(); sendByte(devByte(1'b0), a0); sendByte(sub, a1);
    sendByte(d0, a2); sendByte(d1, a3); busStop();
    check(a0 & a1 & a2 & a3, "R3 burst write acknowledged", {28'd0, a0, a1, a2, a3}, 32'hF);
  endtask

  task automatic regRead(input logic [7:0] sub, output logic [7:0] d);
    logic a0, a1, a2;
    busStart(); sendByte(devByte(1'b0), a0); sendByte(sub, a1);
    busStart(); sendByte(devByte(1'b1), a2); recvByte(1'b0, d); busStop();
    check(a0 & a1 & a2, "R4 read acknowledged", {29'd0, a0, a1, a2}, 32'h7);
  endtask

  task automatic regRead2(input logic [7:0] sub, output logic [7:0] d0, output logic [7:0] d1);
    logic a0, a1, a2;
    busStart(); sendByte(devByte(1'b0), a0); sendByte(sub, a1);
    busStart(); sendByte(devByte(1'b1), a2); recvByte(1'b1, d0); recvByte(1'b0, d1); busStop();
    check(a0 & a1 & a2, "R4 burst read acknowledged", {29'd0, a0, a1, a2}, 32'h7);
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", WDOG, 0);
      finishRun();
    end
  end

  initial begin
    logic [7:0] rd, rd2;
    logic ack;
    int base;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R12 reset state
    check(!sdaOe && !acqPulse && !prbsKickPulse && !prbsGen && !prbsDet && !losOut && !lolOut,
          "R12 reset outputs", {25'd0, sdaOe, acqPulse, prbsKickPulse, prbsGen, prbsDet, losOut, lolOut}, 0);
    regRead(8'h05, rd);
    check(rd == 8'h00, "R12 command readback after reset", rd, 8'h00);
    regRead(8'h06, rd);
    check(rd == 8'h00, "R12 output readback after reset", rd, 8'h00);

    // table walk: R2 R5 R10 R11
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] wSub, wData, rSub, exp;
      {wSub, wData, rSub, exp} = VECS[v];
      regWrite(wSub, wData);
      regRead(rSub, rd);
      check(rd == exp, "R5 table readback", rd, exp);
      if (wSub == 8'h09) begin
        check(prbsGen == (wData[3:1] == 3'b001), "R10 generator decode", prbsGen, wData[3:1] == 3'b001);
        check(prbsDet == (wData[3:1] == 3'b100), "R10 checker decode", prbsDet, wData[3:1] == 3'b100);
      end
    end
    // R11 unmapped write left mapped registers intact
    regRead(8'h06, rd);
    check(rd == 8'h0A, "R11 output register unchanged", rd, 8'h0A);
    regRead(8'h05, rd);
    check(rd == 8'h00, "R11 command register unchanged", rd, 8'h00);

    // R3 R4 burst write then burst read
    regWrite2(8'h08, 8'h01, 8'h0B);
    regRead2(8'h05, rd, rd2);
    check(rd == 8'h01, "R4 burst read byte 0", rd, 8'h01);
    check(rd2 == 8'h0B, "R3 burst byte landed at next sub-address", rd2, 8'h0B);

    // R9 polarity (active-low selected by 0x0B bit 0)
    @(negedge clk);
    check(losOut == 1'b1, "R9 inverted with raw low", losOut, 1);
    losRaw = 1'b1; @(negedge clk);
    check(losOut == 1'b0, "R9 inverted with raw high", losOut, 0);
    regRead(8'h04, rd);
    check(rd == 8'h01, "R12 status loss-of-signal bit", rd, 8'h01);
    regWrite(8'h09, 8'h00);
    check(losOut == 1'b1, "R9 direct polarity", losOut, 1);

    // R7 latched loss of lock (command bit 0 already set)
    lolRaw = 1'b1; repeat (5) @(negedge clk);
    lolRaw = 1'b0; repeat (5) @(negedge clk);
    check(lolOut == 1'b1, "R7 latched after raw drops", lolOut, 1);
    regRead(8'h04, rd);
    check(rd == 8'h03, "R7 status shows latched lock loss", rd, 8'h03);
    regWrite(8'h08, 8'h03);
    check(lolOut == 1'b1, "R7 still latched after clear bit set", lolOut, 1);
    regWrite(8'h08, 8'h01);
    check(lolOut == 1'b0, "R7 cleared by 1-then-0", lolOut, 0);

    // R8 direct mode
    regWrite(8'h08, 8'h00);
    lolRaw = 1'b1; repeat (2) @(negedge clk);
    check(lolOut == 1'b1, "R8 follows raw high", lolOut, 1);
    lolRaw = 1'b0; repeat (2) @(negedge clk);
    check(lolOut == 1'b0, "R8 follows raw low", lolOut, 0);

    // R6 one-shot pulses
    base = acqCnt;
    regWrite(8'h08, 8'h04);
    check(acqCnt == base, "R6 no pulse on writing 1", acqCnt, base);
    regWrite(8'h08, 8'h00);
    check(acqCnt == base + 1, "R6 one pulse on 1-then-0", acqCnt, base + 1);
    regWrite(8'h08, 8'h00);
    check(acqCnt == base + 1, "R6 no pulse on repeated 0", acqCnt, base + 1);
    base = patCnt;
    regWrite(8'h09, 8'h10);
    regWrite(8'h09, 8'h00);
    check(patCnt == base + 1, "R6 pattern kick pulse", patCnt, base + 1);
    check(wideCnt == 0, "R6 pulses one clock wide", wideCnt, 0);

    // R1 address decode with strap
    busStart(); sendByte(8'h82, ack); busStop();
    check(!ack, "R1 foreign address refused", ack, 0);
    addrPin = 1'b1;
    busStart(); sendByte(8'h80, ack); busStop();
    check(!ack, "R1 strap-mismatched address refused", ack, 0);
    regWrite(8'h09, 8'h02);
    regRead(8'h06, rd);
    check(rd == 8'h02, "R1 strapped address accepted", rd, 8'h02);

    done = 1;
    finishRun();
  end
endmodule